// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Ready-to-Send Flow Control

This block takes 8-bit frames in from a serial data pin, one bit per rising edge of a shift clock, least significant bit first. The shift clock comes from one of two sources. It can be generated internally by a programmable divider, which gives a period of 2(N+1) system clocks. It can also be taken from an external clock pin, in which case the clock belongs to the transmitter. Both the external clock and the data pin pass through two-flop synchronizers. Shift edges are then found by edge detection in the system clock domain.

A completed frame is copied into a parallel receive buffer and raises a receive-complete flag. A one-cycle read strobe takes the data and clears that flag. If a frame completes while the previous one is still unread, an overrun flag is raised and the buffer keeps its old byte.

With the external clock selected, the block drives an active-low ready-to-send output for the transmitter:
- It goes low when the receiver is enabled or when the buffer is read.
- It goes high on the first bit of a frame.

So the transmitter is held off until the last byte has been consumed. With the internal clock selected, this output has no function and is held high.

Top module: `sync_serial_rx`

## Requirements
- R1: Reset and output state. While `rst` is high and on the first cycle after it:
  - `rts_o` is 1.
  - `rx_done`, `overrun` and `sclk_out` are 0.
  - `rx_data` is 8'h00.
- R2: With `clk_ext` = 1, a 0-to-1 change of `rx_en` drives `rts_o` to 0 on the next clock edge.
- R3: With `clk_ext` = 1, a `rd_strobe` pulse drives `rts_o` to 0 on the next clock edge, whatever the value of `rx_en`, unless a frame starts on that same edge.
- R4: With `clk_ext` = 1, `rts_o` goes to 1 on the clock edge that takes in the first bit of a frame. That edge comes three system clocks after `sclk_in` rises.
- R5: With `clk_ext` = 1, once `rts_o` is 1 it stays 1 until the buffer is read or `rx_en` rises, including after the frame completes.
- R6: Bits are taken in least significant bit first. On the eighth bit, the assembled byte is placed on `rx_data` and `rx_done` goes to 1. `rx_done` stays 1 until it is read.
- R7: A `rd_strobe` pulse with no frame completing on the same edge clears both `rx_done` and `overrun`.
- R8: A frame that completes while `rx_done` is 1, with no read on the same edge, sets `overrun` and leaves `rx_data` unchanged.
- R9: With `clk_ext` = 0 and `rx_en` = 1, `sclk_out` toggles every `div_n`+1 system clocks and starts low. Its first rise comes within 2(`div_n`+1) clocks of enabling. `sclk_out` is held at 0 whenever the internal clock is not running.
- R10: With `clk_ext` = 0, `rts_o` is 1 from the next clock edge on, even when the buffer is read.
- R11: While `rx_en` is 0, shift-clock edges take in no bits, so no frame completes and `rx_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| clk_ext | input | 1 | Shift clock source: 1 = external pin, 0 = internal divider |
| div_n | input | 8 | Internal divider value N; the period is 2(N+1) clocks |
| sdata_in | input | 1 | Serial data pin, asynchronous |
| sclk_in | input | 1 | External shift clock pin, asynchronous |
| sclk_out | output | 1 | Generated shift clock |
| rts_o | output | 1 | Ready-to-send, active low, used in external mode |
| rd_strobe | input | 1 | One-cycle read of the receive buffer |
| rx_data | output | 8 | Receive buffer |
| rx_done | output | 1 | Receive-complete flag |
| overrun | output | 1 | Frame lost because the buffer was unread |

## Verification
The assertions assume three things about the inputs:
- `rd_strobe` is a single-cycle pulse.
- `clk_ext` changes only while the receiver is idle.
- Every external clock level and data bit is held for at least three system clocks, so the synchronizers capture each edge exactly once.

The stimulus holds each external clock phase for four clocks and sets data three clocks before the rising edge. In internal mode it changes the data pin only after a falling edge of `sclk_out`, with `div_n` large enough that the synchronized value settles before the next rise.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} clk_src_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_n,
  output logic             sclk,
  output logic             rise
);
  logic [DIV_W-1:0] cnt;
  logic             term;

  assign term = (cnt == div_n);
  assign rise = run && term && !sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (term) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               bit_edge,
  input  logic               din,
  output logic [FRAME_W-1:0] word_next,
  output logic               frm_start,
  output logic               frm_done
);
  localparam int CW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;
  logic               take;

  assign take      = en && bit_edge;
  assign word_next = {din, sh[FRAME_W-1:1]};
  assign frm_start = take && (cnt == '0);
  assign frm_done  = take && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      if (rst) sh <= '0;
    end else if (take) begin
      sh  <= word_next;
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_en,
  input  logic               clk_ext,
  input  logic [DIV_W-1:0]   div_n,
  input  logic               sdata_in,
  input  logic               sclk_in,
  output logic               sclk_out,
  output logic               rts_o,
  input  logic               rd_strobe,
  output logic [FRAME_W-1:0] rx_data,
  output logic               rx_done,
  output logic               overrun
);
  import srx_pkg::*;

  clk_src_e           src;
  logic               sclk_s, sdata_s, sclk_q;
  logic               ext_rise, int_rise, bit_edge;
  logic               en_q, en_rise;
  logic [FRAME_W-1:0] word_next;
  logic               frm_start, frm_done;

  assign src = clk_src_e'(clk_ext);

  srx_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_in, sdata_in}),
    .q   ({sclk_s, sdata_s})
  );

  srx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk   (clk),
    .rst   (rst),
    .run   (rx_en && (src == SRC_INT)),
    .div_n (div_n),
    .sclk  (sclk_out),
    .rise  (int_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      en_q   <= rx_en;
    end
  end

  assign ext_rise = sclk_s && !sclk_q;
  assign bit_edge = (src == SRC_EXT) ? ext_rise : int_rise;
  assign en_rise  = rx_en && !en_q;

  srx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .bit_edge  (bit_edge),
    .din       (sdata_s),
    .word_next (word_next),
    .frm_start (frm_start),
    .frm_done  (frm_done)
  );

  // Receive buffer and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_done <= 1'b0;
      overrun <= 1'b0;
    end else if (frm_done) begin
      if (rx_done && !rd_strobe) begin
        overrun <= 1'b1;
      end else begin
        rx_data <= word_next;
        rx_done <= 1'b1;
        overrun <= 1'b0;
      end
    end else if (rd_strobe) begin
      rx_done <= 1'b0;
      overrun <= 1'b0;
    end
  end

  // Ready-to-send: frame start wins over a read or an enable in the same cycle
  always_ff @(posedge clk) begin
    if (rst || src == SRC_INT) rts_o <= 1'b1;
    else if (frm_start)        rts_o <= 1'b1;
    else if (en_rise || rd_strobe) rts_o <= 1'b0;
  end
endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk #(
  parameter int FRAME_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               clk_ext,
  input logic               rx_en,
  input logic               rd_strobe,
  input logic               rts_o,
  input logic               rx_done,
  input logic               overrun,
  input logic [FRAME_W-1:0] rx_data,
  input logic               sclk_out,
  input logic               frm_start,
  input logic               frm_done,
  input logic               en_rise
);
  AST_RTS_INT_HIGH: assert property (@(posedge clk) disable iff (rst)
    !clk_ext |=> rts_o); // R10
  AST_RTS_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    (clk_ext && frm_start) |=> rts_o); // R4
  AST_RTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clk_ext && rts_o && !rd_strobe && !en_rise) |=> rts_o); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rd_strobe) |=> rx_done); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frm_done) |=> (!rx_done && !overrun)); // R7
  AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (rx_done && frm_done && !rd_strobe) |=> (overrun && $stable(rx_data))); // R8
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rx_en || clk_ext) |=> !sclk_out); // R9
  AST_NO_FRAME_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !rx_en |-> !frm_done); // R11
endmodule

bind sync_serial_rx sync_serial_rx_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_ext   (clk_ext),
  .rx_en     (rx_en),
  .rd_strobe (rd_strobe),
  .rts_o     (rts_o),
  .rx_done   (rx_done),
  .overrun   (overrun),
  .rx_data   (rx_data),
  .sclk_out  (sclk_out),
  .frm_start (frm_start),
  .frm_done  (frm_done),
  .en_rise   (en_rise)
);

// File: tb/sync_serial_rx_test.sv
module sync_serial_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       clk_ext = 1'b1;
  logic [7:0] div_n = 8'd3;
  logic       sdata_in = 1'b0;
  logic       sclk_in = 1'b0;
  logic       sclk_out, rts_o, rd_strobe, rx_done, overrun;
  logic [7:0] rx_data;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  sync_serial_rx uut (
    .clk (clk), .rst (rst), .rx_en (rx_en), .clk_ext (clk_ext),
    .div_n (div_n), .sdata_in (sdata_in), .sclk_in (sclk_in),
    .sclk_out (sclk_out), .rts_o (rts_o), .rd_strobe (rd_strobe),
    .rx_data (rx_data), .rx_done (rx_done), .overrun (overrun)
  );

  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_bit(input logic b);
    sdata_in = b;
    ticks(3);
    sclk_in = 1'b1;
    ticks(4);
    sclk_in = 1'b0;
    ticks(1);
  endtask

  task automatic ext_frame(input logic [7:0] v);
    for (int i = 0; i < 8; i++) ext_bit(v[i]);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    ticks(1);
    rd_strobe = 1'b0;
  endtask

  initial begin
    rd_strobe = 1'b0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      report();
    end
  end

  initial begin
    ticks(3);
    // R1: reset state
    chk("R1 rts", rts_o, 1); chk("R1 done", rx_done, 0);
    chk("R1 ovr", overrun, 0); chk("R1 data", rx_data, 8'h00);
    chk("R1 sclk", sclk_out, 0);
    rst = 1'b0;
    ticks(1);
    chk("R1 rts after", rts_o, 1);

    // R11: receiver disabled ignores the clock
    ext_frame(8'h5A);
    ticks(2);
    chk("R11 no done", rx_done, 0);
    chk("R11 rts unchanged", rts_o, 1);

    // R2: enable lowers RTS
    rx_en = 1'b1;
    ticks(1);
    chk("R2 rts low on enable", rts_o, 0);

    // Vector table walk
    for (int k = 0; k < NV; k++) begin
      chk("R3 rts ready", rts_o, 0);
      ext_bit(VEC[k][0]);
      chk("R4 rts high at frame start", rts_o, 1);
      for (int i = 1; i < 8; i++) ext_bit(VEC[k][i]);
      ticks(2);
      chk("R6 data", rx_data, VEC[k]);
      chk("R6 done", rx_done, 1);
      chk("R5 rts held after frame", rts_o, 1);
      chk("R8 no overrun", overrun, 0);
      do_read();
      chk("R7 done cleared", rx_done, 0);
      chk("R3 rts low after read", rts_o, 0);
    end

    // R8: second frame while unread
    ext_frame(8'h96);
    ext_frame(8'h69);
    ticks(2);
    chk("R8 overrun set", overrun, 1);
    chk("R8 data kept", rx_data, 8'h96);
    chk("R5 rts still high", rts_o, 1);
    do_read();
    chk("R7 overrun cleared", overrun, 0);
    chk("R7 done cleared", rx_done, 0);

    // R3: read with receiver disabled still lowers RTS
    ext_frame(8'hC3);
    ticks(2);
    chk("R5 rts high", rts_o, 1);
    rx_en = 1'b0;
    ticks(2);
    chk("R5 rts held when disabled", rts_o, 1);
    do_read();
    chk("R3 rts low with rx_en=0", rts_o, 0);

    // R10: internal mode
    clk_ext = 1'b0;
    ticks(1);
    chk("R10 rts high internal", rts_o, 1);
    chk("R9 sclk idle", sclk_out, 0);
    div_n = 8'd3;
    sdata_in = 1'b1;
    rx_en = 1'b1;
    begin
      int c = 0;
      while (!sclk_out && c < 20) begin ticks(1); c++; end
      chk("R9 first rise within period", (c <= 8) ? 8'd1 : 8'd0, 8'd1);
      c = 0;
      while (sclk_out && c < 20) begin ticks(1); c++; end
      chk("R9 high phase length", 8'(c), 8'd4);
    end
    rx_en = 1'b0;
    ticks(2);
    chk("R9 sclk low when stopped", sclk_out, 0);

    // Internal-clock reception of 8'hB4
    begin
      logic [7:0] v = 8'hB4;
      sdata_in = v[0];
      ticks(3);
      rx_en = 1'b1;
      for (int i = 0; i < 8; i++) begin
        while (!sclk_out) ticks(1);
        while (sclk_out) ticks(1);
        if (i < 7) sdata_in = v[i+1];
      end
      chk("R6 internal data", rx_data, v);
      chk("R6 internal done", rx_done, 1);
      do_read();
      chk("R10 rts high after read", rts_o, 1);
      rx_en = 1'b0;
    end

    finished = 1'b1;
    report();
  end
endmodule